// File: doc/BRIEF.md
# Five-level level-shifted PWM modulator

This block produces switch gate signals for the legs of a five-level diode-clamped converter. Each leg has eight switches in series, numbered 1 (top) to 8 (bottom), arranged as four complementary pairs (1,5), (2,6), (3,7) and (4,8). One shared up/down counter forms a triangle carrier. Four carriers are derived from it by adding fixed offsets, so that together they cover the band from the most negative to the most positive rail and stay in phase. Each leg compares its own signed reference against all four carriers. Each comparison drives one switch pair, and the number of carriers below the reference gives the output level, from -2 to +2.

A strobe rises at every peak and every trough of the triangle, so an outside controller can supply a fresh reference. The block captures each leg's reference only on a strobe cycle, so the reference is constant over each half carrier period. A programmable dead time turns both switches of a pair off for a set number of cycles after each change of that pair's command. The top module holds a parameterised number of legs, three by default, which share the one carrier.

Top module: `pwm5_mod`

## Requirements
- R1: The carrier counter starts at 0 after reset and counts up by one per cycle to the half period P. It then counts down by one per cycle to 0 and repeats, so a full carrier period is 2P cycles. `strobe` is high in the cycle the counter sits at P while rising and in the cycle it sits at 0 while falling, and low otherwise.
- R2: A new `period` value takes effect only at the trough: in the cycle where the falling counter is at 0, the value on `period` is loaded as the next P. A value below 2 is loaded as 2. Consecutive strobes are therefore exactly P cycles apart.
- R3: A leg's reference is captured from `ref_in` only at the clock edge that ends a cycle in which `strobe` is high. A change on `ref_in` at any other time does not affect `level` or `gate`.
- R4: With captured reference r and counter value c, the four carriers are c+P, c, c-P and c-2P. `level` (3-bit two's complement per leg) equals the number of these carriers that r strictly exceeds, minus 2.
- R5: Gate bit `gate[8*l + i - 1]` drives switch i of leg l. When no pair of the leg is in dead time, exactly the switches 3-L through 6-L are on, where L is the level of the previous cycle. For example, +2 turns on 1..4 and -2 turns on 5..8. No more than four switches of a leg are ever on.
- R6: Pair k's upper switch follows the comparison against carrier k: 1 = c+P, 2 = c, 3 = c-P, 4 = c-2P. When that comparison changes, both switches of the pair are off for `dead_time` cycles, sampled at the change, before the new state appears. A new change during the gap restarts it. A `dead_time` of 0 gives a direct switch-over.
- R7: Both switches of a pair are never on together. An upper switch j is never on while a lower switch of a pair below it (pair k > j) is on.
- R8: While reset is asserted the block shows level 0 on every leg, switches 3..6 on (gate byte 0x3C), and `strobe` low. The half period after reset is the parameter `RST_PERIOD`.
- R9: All legs share one carrier and one strobe. Each leg compares only its own slice `ref_in[REF_W*l +: REF_W]` and reports its own level and gate byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | NLEG*REF_W | Signed reference per leg, leg l in slice l |
| period | input | CW | Half carrier period in cycles, loaded at the trough |
| dead_time | input | DT_W | Dead time in cycles after each pair change |
| gate | output | NLEG*8 | Switch gates, bit 8l+i-1 is switch i of leg l |
| level | output | NLEG*3 | Selected level per leg, two's complement -2..+2 |
| strobe | output | 1 | High at each carrier peak and trough |

## Verification
The bench sweeps the reference across the full band and slightly past it on every leg, at several half periods and dead times. This catches a comparison that uses >= instead of > (at the carrier peak and trough a full-scale reference would show the wrong level) and carrier offsets that are off by one band. It makes large steps in the reference so that several pairs change at once, and toggles the reference every cycle between strobes. A block that captures the reference outside strobe cycles, or that fails to restart the dead-time gap, would show gates or levels that differ from the arithmetic expectation. It loads half periods of 0 and 1 to catch a missing clamp, which would give strobes on every cycle, and reasserts reset partway through to confirm the level-0 gate pattern.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
   localparam int SW_PER_LEG = 8;
   localparam int PAIRS      = 4;
   localparam int LVL_W      = 3;
   localparam int MIN_HALF   = 2;
   typedef logic signed [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pwm5_carrier.sv
module pwm5_carrier
   import pwm5_pkg::*;
#(
   parameter int CW         = 14,
   parameter int RST_PERIOD = 8333
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] period_in,
   output logic [CW-1:0] count,
   output logic [CW-1:0] period_q,
   output logic          strobe
);
   localparam logic [CW-1:0] HALF_MIN = CW'(MIN_HALF);
   localparam logic [CW-1:0] HALF_RST = CW'(RST_PERIOD);

   logic          rising;
   logic [CW-1:0] half_next;

   assign half_next = (period_in < HALF_MIN) ? HALF_MIN : period_in;
   assign strobe    = rising ? (count == period_q) : (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         rising   <= 1'b1;
         period_q <= HALF_RST;
      end else if (rising) begin
         if (count == period_q) begin
            rising <= 1'b0;
            count  <= count - 1'b1;
         end else begin
            count  <= count + 1'b1;
         end
      end else if (count == '0) begin
         rising   <= 1'b1;
         count    <= CW'(1);
         period_q <= half_next;
      end else begin
         count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/pwm5_deadtime.sv
module pwm5_deadtime #(
   parameter int DT_W         = 6,
   parameter bit INIT         = 1'b0,
   parameter bit DEAD_TIME_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd,
   input  logic [DT_W-1:0] dt,
   output logic            hi,
   output logic            lo
);
   logic state;

   generate
      if (DEAD_TIME_EN) begin : g_gap
         logic [DT_W-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state <= INIT;
               hold  <= '0;
            end else if (cmd != state) begin
               state <= cmd;
               hold  <= dt;
            end else if (hold != '0) begin
               hold <= hold - 1'b1;
            end
         end
         assign hi = (hold == '0) &&  state;
         assign lo = (hold == '0) && !state;
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state <= INIT;
            else        state <= cmd;
         end
         assign hi =  state;
         assign lo = !state;
      end
   endgenerate
endmodule

// File: rtl/pwm5_leg.sv
module pwm5_leg
   import pwm5_pkg::*;
#(
   parameter int REF_W        = 16,
   parameter int CW           = 14,
   parameter int DT_W         = 6,
   parameter bit DEAD_TIME_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_in,
   input  logic                    load,
   input  logic [CW-1:0]           count,
   input  logic [CW-1:0]           period_q,
   input  logic [DT_W-1:0]         dead_time,
   output logic [SW_PER_LEG-1:0]   gate,
   output lvl_t                    level
);
   localparam int XW = REF_W + 1;

   logic signed [REF_W-1:0] ref_q;
   logic signed [XW-1:0]    ref_x;
   logic signed [XW-1:0]    cnt_x;
   logic signed [XW-1:0]    per_x;
   logic [PAIRS-1:0]        above;
   logic [LVL_W-1:0]        n_above;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ref_q <= '0;
      else if (load) ref_q <= ref_in;
   end

   assign ref_x = XW'(ref_q);
   assign cnt_x = signed'(XW'(count));
   assign per_x = signed'(XW'(period_q));

   generate
      for (genvar k = 0; k < PAIRS; k++) begin : g_pair
         logic signed [XW-1:0] car;
         if (k == 0) begin : g_top
            assign car = cnt_x + per_x;
         end else if (k == 1) begin : g_upper_mid
            assign car = cnt_x;
         end else if (k == 2) begin : g_lower_mid
            assign car = cnt_x - per_x;
         end else begin : g_bottom
            assign car = cnt_x - per_x - per_x;
         end
         assign above[k] = (ref_x > car);

         pwm5_deadtime #(
            .DT_W        (DT_W),
            .INIT        (k >= 2),
            .DEAD_TIME_EN(DEAD_TIME_EN)
         ) u_dt (
            .clk  (clk),
            .rst_n(rst_n),
            .cmd  (above[k]),
            .dt   (dead_time),
            .hi   (gate[k]),
            .lo   (gate[k+PAIRS])
         );
      end
   endgenerate

   assign n_above = LVL_W'($countones(above));
   assign level   = lvl_t'(n_above - LVL_W'(2));
endmodule

// File: rtl/pwm5_mod.sv
module pwm5_mod
   import pwm5_pkg::*;
#(
   parameter int NLEG         = 3,
   parameter int REF_W        = 16,
   parameter int CW           = 14,
   parameter int DT_W         = 6,
   parameter int RST_PERIOD   = 8333,
   parameter bit DEAD_TIME_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NLEG*REF_W-1:0]       ref_in,
   input  logic [CW-1:0]               period,
   input  logic [DT_W-1:0]             dead_time,
   output logic [NLEG*SW_PER_LEG-1:0]  gate,
   output logic [NLEG*LVL_W-1:0]       level,
   output logic                        strobe
);
   logic [CW-1:0] count;
   logic [CW-1:0] period_q;

   generate
      if (NLEG < 1) begin : g_bad_nleg
         $error("pwm5_mod: NLEG must be at least 1");
      end
      if (CW < 2) begin : g_bad_cw
         $error("pwm5_mod: CW must be at least 2");
      end
      if (REF_W < CW + 2) begin : g_bad_refw
         $error("pwm5_mod: REF_W must hold twice the largest half period plus sign");
      end
      if (DT_W < 1) begin : g_bad_dtw
         $error("pwm5_mod: DT_W must be at least 1");
      end
      if (RST_PERIOD < MIN_HALF || RST_PERIOD >= (1 << CW)) begin : g_bad_rstp
         $error("pwm5_mod: RST_PERIOD out of range for CW");
      end
   endgenerate

   pwm5_carrier #(
      .CW        (CW),
      .RST_PERIOD(RST_PERIOD)
   ) u_carrier (
      .clk      (clk),
      .rst_n    (rst_n),
      .period_in(period),
      .count    (count),
      .period_q (period_q),
      .strobe   (strobe)
   );

   generate
      for (genvar l = 0; l < NLEG; l++) begin : g_leg
         lvl_t leg_level;
         pwm5_leg #(
            .REF_W       (REF_W),
            .CW          (CW),
            .DT_W        (DT_W),
            .DEAD_TIME_EN(DEAD_TIME_EN)
         ) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_in   (ref_in[l*REF_W +: REF_W]),
            .load     (strobe),
            .count    (count),
            .period_q (period_q),
            .dead_time(dead_time),
            .gate     (gate[l*SW_PER_LEG +: SW_PER_LEG]),
            .level    (leg_level)
         );
         assign level[l*LVL_W +: LVL_W] = leg_level;
      end
   endgenerate
endmodule

// File: rtl/pwm5_mod_chk.sv
module pwm5_mod_chk #(
   parameter int NLEG         = 3,
   parameter int DT_W         = 6,
   parameter bit DEAD_TIME_EN = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NLEG*8-1:0]   gate,
   input logic [NLEG*3-1:0]   level,
   input logic                strobe,
   input logic [DT_W-1:0]     dead_time
);
   // R1
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   generate
      for (genvar l = 0; l < NLEG; l++) begin : g_leg
         // R4
         level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(level[l*3 +: 3]) >= -3'sd2) && ($signed(level[l*3 +: 3]) <= 3'sd2));
         // R5
         on_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gate[l*8 +: 8]) <= 4);
         for (genvar k = 0; k < 4; k++) begin : g_pair
            // R7
            pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !(gate[l*8 + k] && gate[l*8 + k + 4]));
            if (DEAD_TIME_EN) begin : g_gap
               // R6
               gap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                  ($past(gate[l*8 + k]) && gate[l*8 + k + 4]) |-> ($past(dead_time) == '0));
               // R6
               gap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
                  ($past(gate[l*8 + k + 4]) && gate[l*8 + k]) |-> ($past(dead_time) == '0));
            end
            for (genvar j = 0; j < k; j++) begin : g_below
               // R7
               no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
                  !(gate[l*8 + j] && gate[l*8 + k + 4]));
            end
         end
      end
   endgenerate
endmodule

bind pwm5_mod pwm5_mod_chk #(
   .NLEG        (NLEG),
   .DT_W        (DT_W),
   .DEAD_TIME_EN(DEAD_TIME_EN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .gate     (gate),
   .level    (level),
   .strobe   (strobe),
   .dead_time(dead_time)
);

// File: tb/pwm5_mod_test.sv
module pwm5_mod_test;
   localparam int NLEG  = 3;
   localparam int REF_W = 8;
   localparam int CW    = 5;
   localparam int DT_W  = 3;
   localparam int RSTP  = 5;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NLEG*REF_W-1:0]  ref_in = '0;
   logic [CW-1:0]          period = '0;
   logic [DT_W-1:0]        dead_time = '0;
   logic [NLEG*8-1:0]      gate;
   logic [NLEG*3-1:0]      level;
   logic                   strobe;

   pwm5_mod #(
      .NLEG(NLEG), .REF_W(REF_W), .CW(CW), .DT_W(DT_W),
      .RST_PERIOD(RSTP), .DEAD_TIME_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .period(period),
      .dead_time(dead_time), .gate(gate), .level(level), .strobe(strobe)
   );

   always #10 clk = ~clk;

   int m_c, m_up, m_p;
   int m_ref [NLEG];
   int m_app [NLEG][4];
   int m_hold[NLEG][4];
   int in_ref[NLEG];
   int in_per, in_dt;
   int checks = 0;
   int fails  = 0;

   function automatic bit mdl_strobe();
      return (m_up != 0 && m_c == m_p) || (m_up == 0 && m_c == 0);
   endfunction

   function automatic int mdl_level(int l);
      int n = 0;
      for (int k = 0; k < 4; k++)
         if (m_ref[l] > m_c + (1 - k) * m_p) n++;
      return n - 2;
   endfunction

   function automatic int exp_gate(int l);
      int busy = 0;
      int g = 0;
      int lv;
      for (int k = 0; k < 4; k++) if (m_hold[l][k] != 0) busy = 1;
      if (busy == 0) begin
         // R5: level L turns on switches 3-L .. 6-L
         lv = -2;
         for (int k = 0; k < 4; k++) lv += m_app[l][k];
         for (int i = 1; i <= 8; i++)
            if (i >= 3 - lv && i <= 6 - lv) g |= (1 << (i - 1));
      end else begin
         for (int k = 0; k < 4; k++) begin
            if (m_hold[l][k] == 0 && m_app[l][k] != 0) g |= (1 << k);
            if (m_hold[l][k] == 0 && m_app[l][k] == 0) g |= (1 << (k + 4));
         end
      end
      return g;
   endfunction

   task automatic mdl_reset();
      m_c = 0; m_up = 1; m_p = RSTP;
      for (int l = 0; l < NLEG; l++) begin
         m_ref[l] = 0;
         for (int k = 0; k < 4; k++) begin
            m_app[l][k]  = (k >= 2) ? 1 : 0;
            m_hold[l][k] = 0;
         end
      end
   endtask

   task automatic mdl_step();
      bit stb = mdl_strobe();
      for (int l = 0; l < NLEG; l++)
         for (int k = 0; k < 4; k++) begin
            int cmd = (m_ref[l] > m_c + (1 - k) * m_p) ? 1 : 0;
            if (cmd != m_app[l][k]) begin
               m_app[l][k]  = cmd;
               m_hold[l][k] = in_dt;
            end else if (m_hold[l][k] > 0) begin
               m_hold[l][k]--;
            end
         end
      if (stb) for (int l = 0; l < NLEG; l++) m_ref[l] = in_ref[l];
      if (m_up != 0) begin
         if (m_c == m_p) begin m_up = 0; m_c--; end
         else m_c++;
      end else if (m_c == 0) begin
         m_up = 1; m_c = 1;
         m_p = (in_per < 2) ? 2 : in_per;
      end else begin
         m_c--;
      end
   endtask

   task automatic check_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive();
      for (int l = 0; l < NLEG; l++) ref_in[l*REF_W +: REF_W] = REF_W'(in_ref[l]);
      period    = CW'(in_per);
      dead_time = DT_W'(in_dt);
   endtask

   task automatic tick();
      @(negedge clk);
      if (!rst_n) mdl_reset();
      else        mdl_step();
      check_int("R1 strobe", int'(strobe), int'(mdl_strobe()));
      for (int l = 0; l < NLEG; l++) begin
         check_int("R3/R4/R9 level", int'($signed(level[l*3 +: 3])), mdl_level(l));
         check_int("R5/R6/R9 gates", int'(gate[l*8 +: 8]), exp_gate(l));
      end
   endtask

   task automatic run(int n);
      repeat (n) tick();
   endtask

   task automatic reset_checks();
      for (int l = 0; l < NLEG; l++) begin
         check_int("R8 reset gates", int'(gate[l*8 +: 8]), 'h3C);
         check_int("R8 reset level", int'($signed(level[l*3 +: 3])), 0);
      end
      check_int("R8 reset strobe", int'(strobe), 0);
   endtask

   task automatic measure_gap(int exp);
      int guard = 0;
      int gap;
      while (!strobe && guard < 200) begin tick(); guard++; end
      tick();
      gap = 1;
      while (!strobe && gap < 200) begin tick(); gap++; end
      check_int("R2 strobe spacing", gap, exp);
   endtask

   task automatic set_refs(int v);
      in_ref[0] = v; in_ref[1] = -v; in_ref[2] = v / 2;
      drive();
   endtask

   initial begin
      #(20 * 60000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      in_per = RSTP; in_dt = 0;
      set_refs(0);
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin tick(); reset_checks(); end
      rst_n = 1'b1;

      // full-band sweep, no dead time
      for (int v = -11; v <= 11; v++) begin set_refs(v); run(13); end

      // sweep with dead time
      in_dt = 2;
      for (int v = -11; v <= 11; v += 2) begin set_refs(v); run(11); end

      // large steps: several pairs change together
      in_dt = 3;
      for (int i = 0; i < 6; i++) begin set_refs((i % 2 == 0) ? 10 : -10); run(10); end
      for (int i = 0; i < 4; i++) begin set_refs((i % 2 == 0) ? 6 : -4); run(7); end

      // period clamp and change at trough
      in_dt = 1;
      in_per = 0; drive(); run(14);
      measure_gap(2);
      for (int v = -5; v <= 5; v++) begin set_refs(v); run(5); end
      in_per = 7; drive(); run(10);
      measure_gap(7);
      for (int v = -15; v <= 15; v += 2) begin set_refs(v); run(15); end
      in_per = 1; drive(); run(20);
      measure_gap(2);
      in_per = 7; drive(); run(12);

      // R3: reference toggled every cycle, only strobe cycles capture it
      for (int i = 0; i < 40; i++) begin set_refs((i % 2 == 0) ? 3 : -3); run(1); end

      // mid-run reset
      rst_n = 1'b0;
      for (int i = 0; i < 2; i++) begin tick(); reset_checks(); end
      rst_n = 1'b1;
      in_dt = 0; set_refs(9);
      run(30);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule